// File: doc/BRIEF.md
# Carrier Presence Detector

This block decides whether a frequency-shift-keyed carrier is present on a telephone line. A demodulator front end gives it two flags each clock cycle. One flag says a tone was seen inside the signalling band. The other says the received level is above the sensitivity threshold. A cycle counts as carrier only when both flags are high. The block drives an active-low detect output. Because that output can wake the rest of the receiver, it must not chatter.

The timing is asymmetric, which gives hysteresis. The output asserts only after a long run of carrier cycles, about 14 ms at the 3.58 MHz clock. During that run, short holes of less than a bit time are tolerated. Once asserted, the output stays low until the line has been quiet for about 8 ms. A brief dropout of the carrier therefore never ends a detection. A power-down input clears all progress and holds the output high. All three windows are parameters counted in clock cycles.

Top module: `carrier_presence_det`

## Requirements
- R1: After reset, `carrier_det_n` is 1 and no acquisition progress is held.
- R2: While `carrier_det_n` is 1 and `pwr_down` is 0, each clock edge with a qualified carrier cycle adds one to an acquisition count. `carrier_det_n` goes to 0 at the edge that samples the ACQ_CYCLES-th such cycle.
- R3: A cycle is a qualified carrier cycle only when `tone_in_band` and `level_ok` are both 1. Either flag alone is treated as absence.
- R4: Before assertion, GAP_CYCLES consecutive cycles without carrier discard the acquisition count. Counting then restarts from zero.
- R5: Before assertion, a run of fewer than GAP_CYCLES cycles without carrier keeps the acquisition count, and later carrier cycles add to it.
- R6: While `carrier_det_n` is 0, a run of fewer than REL_CYCLES cycles without carrier leaves it at 0.
- R7: While `carrier_det_n` is 0, it returns to 1 at the edge that samples the REL_CYCLES-th consecutive cycle without carrier.
- R8: While `carrier_det_n` is 0, any qualified carrier cycle restarts the release count from zero.
- R9: An edge that samples `pwr_down` = 1 sets `carrier_det_n` to 1 and clears all acquisition and release progress, whatever the tone flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock (3.58 MHz in the target use) |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | 1 forces the detector idle and the output high |
| tone_in_band | input | 1 | Per-cycle flag from the demodulator: tone inside the band |
| level_ok | input | 1 | Per-cycle flag: signal level at or above the sensitivity threshold |
| carrier_det_n | output | 1 | Active-low carrier detect, registered |

## Verification
The detector is first driven with single qualifying flags (tone only, then level only) to show that neither flag alone starts acquisition. Acquisition is then tried with an unbroken carrier, with holes just under the gap limit, and with holes exactly at the limit. Together these separate a count that keeps progress from one that discards it. While asserted, dropouts one cycle short of the release window, dropouts broken by a single carrier cycle, and a full quiet window show whether the release timer bridges, restarts and expires at the right edge. Power-down is applied both mid-acquisition and mid-detection. A long pseudo-random flag pattern is then compared against a behavioural model on every clock.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    // Default windows at a 3.58 MHz clock
    localparam int unsigned DEF_ACQ_CYCLES = 50120; // ~14 ms
    localparam int unsigned DEF_GAP_CYCLES = 2983;  // ~one 1200 bit/s bit
    localparam int unsigned DEF_REL_CYCLES = 28640; // ~8 ms

    typedef struct packed {
        logic detected;
    } det_state_t;

endpackage

// File: rtl/cpd_acq_timer.sv
module cpd_acq_timer #(
    parameter int unsigned ACQ_CYCLES = 50120,
    parameter int unsigned GAP_CYCLES = 2983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic carrier,
    output logic acq_done
);
    localparam int AW = $clog2(ACQ_CYCLES + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_CYCLES - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    typedef struct packed {
        logic [AW-1:0] acq;
        logic [GW-1:0] gap;
    } acq_state_t;

    acq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        acq_done = 1'b0;
        if (clear) begin
            s_d = '0;
        end else if (carrier) begin
            s_d.gap = '0;
            if (s_q.acq == ACQ_LAST) begin
                acq_done = 1'b1;
                s_d.acq  = '0;
            end else begin
                s_d.acq = s_q.acq + 1'b1;
            end
        end else if (s_q.gap == GAP_LAST) begin
            s_d = '0;
        end else begin
            s_d.gap = s_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_ACQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.acq <= ACQ_LAST); // R2
    AST_GAP_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !carrier && s_q.gap == GAP_LAST) |=> (s_q.acq == '0)); // R4
    AST_SHORT_GAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !carrier && s_q.gap != GAP_LAST) |=> $stable(s_q.acq)); // R5

endmodule

// File: rtl/cpd_rel_timer.sv
module cpd_rel_timer #(
    parameter int unsigned REL_CYCLES = 28640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic carrier,
    output logic rel_done
);
    localparam int RW = $clog2(REL_CYCLES + 1);
    localparam logic [RW-1:0] REL_LAST = RW'(REL_CYCLES - 1);

    typedef struct packed {
        logic [RW-1:0] quiet;
    } rel_state_t;

    rel_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        rel_done = 1'b0;
        if (!armed || carrier) begin
            s_d.quiet = '0;
        end else if (s_q.quiet == REL_LAST) begin
            rel_done  = 1'b1;
            s_d.quiet = '0;
        end else begin
            s_d.quiet = s_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_REL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && carrier) |=> (s_q.quiet == '0)); // R8
    AST_REL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.quiet <= REL_LAST); // R7

endmodule

// File: rtl/carrier_presence_det.sv
module carrier_presence_det
    import cpd_pkg::*;
#(
    parameter int unsigned ACQ_CYCLES = DEF_ACQ_CYCLES,
    parameter int unsigned GAP_CYCLES = DEF_GAP_CYCLES,
    parameter int unsigned REL_CYCLES = DEF_REL_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic tone_in_band,
    input  logic level_ok,
    output logic carrier_det_n
);
    det_state_t st_d, st_q;
    logic carrier;
    logic acq_clear;
    logic rel_armed;
    logic acq_done;
    logic rel_done;

    assign carrier   = tone_in_band & level_ok;
    assign acq_clear = pwr_down | st_q.detected;
    assign rel_armed = st_q.detected & ~pwr_down;

    cpd_acq_timer #(
        .ACQ_CYCLES(ACQ_CYCLES),
        .GAP_CYCLES(GAP_CYCLES)
    ) acq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acq_clear),
        .carrier (carrier),
        .acq_done(acq_done)
    );

    cpd_rel_timer #(
        .REL_CYCLES(REL_CYCLES)
    ) rel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (rel_armed),
        .carrier (carrier),
        .rel_done(rel_done)
    );

    always_comb begin
        st_d = st_q;
        if (pwr_down)           st_d.detected = 1'b0;
        else if (st_q.detected) st_d.detected = ~rel_done;
        else                    st_d.detected = acq_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carrier_det_n = ~st_q.detected;

    AST_PD_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> carrier_det_n); // R9
    AST_ASSERT_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_det_n) |-> $past(tone_in_band && level_ok)); // R3
    AST_HOLD_ON_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_det_n && !pwr_down && carrier) |=> !carrier_det_n); // R6
    AST_RELEASE_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(carrier_det_n) && !$past(pwr_down)) |-> !$past(tone_in_band && level_ok)); // R7

endmodule

// File: tb/carrier_presence_det_tb_top.sv
module carrier_presence_det_tb_top;
    localparam int ACQ = 12;
    localparam int GAP = 3;
    localparam int REL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic tone_in_band = 1'b0;
    logic level_ok = 1'b0;
    logic carrier_det_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model
    bit m_det;
    int m_acc, m_miss, m_quiet;

    always #2 clk = ~clk;

    carrier_presence_det #(.ACQ_CYCLES(ACQ), .GAP_CYCLES(GAP), .REL_CYCLES(REL)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .tone_in_band(tone_in_band), .level_ok(level_ok),
        .carrier_det_n(carrier_det_n)
    );

    task automatic model_edge(input bit t, input bit l, input bit pd);
        bit c = t & l;
        if (pd) begin
            m_det = 0; m_acc = 0; m_miss = 0; m_quiet = 0;
        end else if (!m_det) begin
            if (c) begin
                m_acc++; m_miss = 0;
                if (m_acc == ACQ) begin m_det = 1; m_acc = 0; m_quiet = 0; end
            end else begin
                m_miss++;
                if (m_miss == GAP) begin m_acc = 0; m_miss = 0; end
            end
        end else begin
            if (c) m_quiet = 0;
            else begin
                m_quiet++;
                if (m_quiet == REL) begin m_det = 0; m_quiet = 0; m_acc = 0; m_miss = 0; end
            end
        end
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (carrier_det_n !== exp) begin
            errors++;
            $display("FAIL %s carrier_det_n actual=%b expected=%b at %0t", req, carrier_det_n, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string req, input bit t, input bit l, input bit pd);
        tone_in_band = t; level_ok = l; pwr_down = pd;
        @(posedge clk);
        model_edge(t, l, pd);
        @(negedge clk);
        check(req, ~m_det);
    endtask

    task automatic run(input string req, input int n, input bit t, input bit l, input bit pd);
        for (int i = 0; i < n; i++) step(req, t, l, pd);
    endtask

    initial begin
        m_det = 0; m_acc = 0; m_miss = 0; m_quiet = 0;
        repeat (3) @(negedge clk);
        check("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b1);

        // R3: single flags never count
        run("R3", 20, 1, 0, 0);
        run("R3", 20, 0, 1, 0);
        run("R3", 2, 0, 0, 0);
        // R2: unbroken carrier asserts on the ACQ-th cycle
        run("R2", ACQ - 1, 1, 1, 0);
        check("R2", 1'b1);
        step("R2", 1, 1, 0);
        check("R2", 1'b0);
        // R6: dropout one short of the release window
        run("R6", REL - 1, 0, 0, 0);
        check("R6", 1'b0);
        // R8: one carrier cycle restarts the release window
        step("R8", 1, 1, 0);
        run("R8", REL - 1, 0, 0, 0);
        check("R8", 1'b0);
        step("R8", 1, 0, 0);   // tone without level is absence: completes window
        check("R7", 1'b1);
        // R5: short holes keep progress
        run("R5", 5, 1, 1, 0);
        run("R5", GAP - 1, 0, 0, 0);
        run("R5", ACQ - 5 - 1, 1, 1, 0);
        check("R5", 1'b1);
        step("R5", 1, 1, 0);
        check("R5", 1'b0);
        // R7: full quiet window releases
        run("R7", REL, 0, 0, 0);
        check("R7", 1'b1);
        // R4: a hole of GAP cycles discards progress
        run("R4", ACQ - 2, 1, 1, 0);
        run("R4", GAP, 0, 0, 0);
        run("R4", ACQ - 1, 1, 1, 0);
        check("R4", 1'b1);
        step("R4", 1, 1, 0);
        check("R4", 1'b0);
        // R9: power-down while asserted, with carrier held
        step("R9", 1, 1, 1);
        check("R9", 1'b1);
        run("R9", 5, 1, 1, 1);
        // R9: power-down mid-acquisition clears progress
        run("R9", ACQ - 2, 1, 1, 0);
        step("R9", 1, 1, 1);
        run("R9", ACQ - 1, 1, 1, 0);
        check("R9", 1'b1);
        step("R9", 1, 1, 0);
        check("R9", 1'b0);
        run("R7", REL, 0, 0, 0);
        // mixed pseudo-random pattern, compared every clock
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step("R2", lfsr[0] | lfsr[1] | lfsr[2], lfsr[3] | lfsr[4] | lfsr[5],
                     (lfsr[15:9] == 7'h7F));
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule